// File: doc/BRIEF.md
# Release-Consistency Issue Gate

This block sits between a processor's in-order memory request stream and the memory system. It decides when each request may leave. Every request carries a two-bit class: data read, data write, acquire (lock) or release (unlock). Data operations must not start while an earlier acquire is still in flight. A release must not start while any earlier data operation is still in flight. Acquires and releases stay in program order among themselves.

Apart from these rules, operations overlap freely. Data issued before an acquire may still be outstanding when the acquire goes out. Data issued after a release does not wait for that release to finish.

The gate keeps one outstanding-operation counter per class (data, acquire, release). Each counter rises on issue and falls on that class's completion pulse. Ready is a combinational function of the request class and the registered counters. A blocked request holds ready low, and requests behind it are never reordered past it.

Top module: `rcg_issue_gate`

## Requirements
- R1: After reset all counters are zero, reqReady is high for every class and issueStrobe is low while reqValid is low.
- R2: reqKind encodes 0 = data read, 1 = data write, 2 = acquire, 3 = release. issueStrobe is high exactly in a cycle where reqValid and reqReady are both high, and each such cycle counts as one issued operation of that class.
- R3: A data read or write is not ready while any acquire is outstanding.
- R4: A release is not ready while any data operation is outstanding.
- R5: An acquire or release is not ready while any acquire or release is outstanding, so synchronization operations issue and complete in program order.
- R6: A data read or write is ready while a release is outstanding, provided no acquire is outstanding and the data counter is not full.
- R7: An acquire is ready while data operations are outstanding, provided no acquire or release is outstanding.
- R8: The data counter holds up to 2^CNT_W-1 (15 by default) outstanding operations. At that count, data requests are not ready until a data completion arrives.
- R9: A completion pulse for a class with zero outstanding operations is ignored and leaves that counter at zero.
- R10: An issue and a completion of the same class in one cycle leave that counter unchanged. A completion takes effect on reqReady in the cycle after its pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqKind | input | 2 | Request class (0 read, 1 write, 2 acquire, 3 release) |
| reqReady | output | 1 | Request may issue this cycle |
| issueStrobe | output | 1 | Request issued this cycle |
| doneData | input | 1 | One data read or write completed |
| doneAcq | input | 1 | One acquire completed |
| doneRel | input | 1 | One release completed |

## Verification
reqReady and issueStrobe depend combinationally on the request and on registered counters. Both are therefore due in the same cycle a request is presented. An issue or completion changes a counter at the next rising edge, so its effect on reqReady is due one cycle later. The bench drives inputs at the falling edge and samples 2 ns after it, before the following rising edge. Each check therefore sees exactly the counter state left by the previous edge.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_ACQ   = 2'd2,
    KIND_REL   = 2'd3
  } reqKind_e;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic incData;
    logic incAcq;
    logic incRel;
  } ctrlStrobe_t;

  // Counter flags returned to control
  typedef struct packed {
    logic dataZero;
    logic dataFull;
    logic acqZero;
    logic acqFull;
    logic relZero;
    logic relFull;
  } cntStatus_t;

  localparam int NUM_CLASSES = 3;
  localparam int IDX_DATA    = 0;
  localparam int IDX_ACQ     = 1;
  localparam int IDX_REL     = 2;

endpackage

// File: rtl/rcg_counter.sv
module rcg_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic inc,
  input  logic dec,
  output logic zero,
  output logic full
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count;
  logic             decEff;

  assign decEff = dec && (count != '0);
  assign zero   = (count == '0);
  assign full   = (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (inc && !decEff) begin
      count <= count + 1'b1;
    end else if (decEff && !inc) begin
      count <= count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (full && inc) |-> dec);  // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (zero && dec && !inc) |=> zero);  // R9

  AST_NET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inc && dec && !zero) |=> $stable(count));  // R10

endmodule

// File: rtl/rcg_counters.sv
module rcg_counters
  import rcg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        doneData,
  input  logic        doneAcq,
  input  logic        doneRel,
  output cntStatus_t  status
);

  logic [NUM_CLASSES-1:0] incVec;
  logic [NUM_CLASSES-1:0] decVec;
  logic [NUM_CLASSES-1:0] zeroVec;
  logic [NUM_CLASSES-1:0] fullVec;

  assign incVec[IDX_DATA] = strobe.incData;
  assign incVec[IDX_ACQ]  = strobe.incAcq;
  assign incVec[IDX_REL]  = strobe.incRel;
  assign decVec[IDX_DATA] = doneData;
  assign decVec[IDX_ACQ]  = doneAcq;
  assign decVec[IDX_REL]  = doneRel;

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : gCnt
    rcg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .inc  (incVec[g]),
      .dec  (decVec[g]),
      .zero (zeroVec[g]),
      .full (fullVec[g])
    );
  end

  assign status.dataZero = zeroVec[IDX_DATA];
  assign status.dataFull = fullVec[IDX_DATA];
  assign status.acqZero  = zeroVec[IDX_ACQ];
  assign status.acqFull  = fullVec[IDX_ACQ];
  assign status.relZero  = zeroVec[IDX_REL];
  assign status.relFull  = fullVec[IDX_REL];

  AST_DATA_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incData |-> status.acqZero);  // R3

  AST_REL_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incRel |-> status.dataZero);  // R4

  AST_SYNC_FIFO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incAcq || strobe.incRel) |-> (status.acqZero && status.relZero));  // R5

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !(!status.acqZero && !status.relZero));  // R5

endmodule

// File: rtl/rcg_ctrl.sv
module rcg_ctrl
  import rcg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  cntStatus_t  status,
  output logic        reqReady,
  output logic        issueStrobe,
  output ctrlStrobe_t strobe
);

  reqKind_e kind;
  logic     syncIdle;

  assign kind     = reqKind_e'(reqKind);
  assign syncIdle = status.acqZero && status.relZero;

  always_comb begin
    unique case (kind)
      KIND_READ, KIND_WRITE: reqReady = status.acqZero && !status.dataFull;
      KIND_ACQ:              reqReady = syncIdle && !status.acqFull;
      KIND_REL:              reqReady = syncIdle && status.dataZero && !status.relFull;
      default:               reqReady = 1'b0;
    endcase
  end

  assign issueStrobe = reqValid && reqReady;

  always_comb begin
    strobe         = '0;
    strobe.incData = issueStrobe && ((kind == KIND_READ) || (kind == KIND_WRITE));
    strobe.incAcq  = issueStrobe && (kind == KIND_ACQ);
    strobe.incRel  = issueStrobe && (kind == KIND_REL);
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));  // R2

  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strobe != '0) |-> reqValid);  // R2

endmodule

// File: rtl/rcg_issue_gate.sv
module rcg_issue_gate
  import rcg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  output logic       reqReady,
  output logic       issueStrobe,
  input  logic       doneData,
  input  logic       doneAcq,
  input  logic       doneRel
);

  ctrlStrobe_t strobe;
  cntStatus_t  status;

  rcg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqKind     (reqKind),
    .status      (status),
    .reqReady    (reqReady),
    .issueStrobe (issueStrobe),
    .strobe      (strobe)
  );

  rcg_counters #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .doneData (doneData),
    .doneAcq  (doneAcq),
    .doneRel  (doneRel),
    .status   (status)
  );

  AST_ISSUE_IS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    issueStrobe |-> (reqValid && reqReady));  // R2

endmodule

// File: tb/sim_rcg_issue_gate.sv
module sim_rcg_issue_gate;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic       doneData = 1'b0;
  logic       doneAcq = 1'b0;
  logic       doneRel = 1'b0;
  logic       reqReady;
  logic       issueStrobe;

  int checks = 0;
  int fails  = 0;

  localparam logic [1:0] K_RD  = 2'd0;
  localparam logic [1:0] K_WR  = 2'd1;
  localparam logic [1:0] K_ACQ = 2'd2;
  localparam logic [1:0] K_REL = 2'd3;

  always #10 clk = ~clk;  // 50 MHz

  rcg_issue_gate u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqReady(reqReady), .issueStrobe(issueStrobe),
    .doneData(doneData), .doneAcq(doneAcq), .doneRel(doneRel)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // Present a request for one half cycle only; never issues
  task automatic probe(input logic [1:0] k, input logic expReady, input string tag);
    @(negedge clk);
    reqValid = 1'b1;
    reqKind  = k;
    #2;
    chk(tag, reqReady, expReady);
    chk(tag, issueStrobe, expReady);
    reqValid = 1'b0;
  endtask

  // Issue one request; it must be accepted in the same cycle
  task automatic issueOne(input logic [1:0] k, input string tag);
    @(negedge clk);
    reqValid = 1'b1;
    reqKind  = k;
    #2;
    chk(tag, issueStrobe, 1'b1);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] k);
    @(negedge clk);
    if (k == K_ACQ) doneAcq = 1'b1;
    else if (k == K_REL) doneRel = 1'b1;
    else doneData = 1'b1;
    @(posedge clk);
    #1;
    doneAcq  = 1'b0;
    doneRel  = 1'b0;
    doneData = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      reqKind = 2'(k);
      #1;
      chk("R1 ready after reset", reqReady, 1'b1);
      chk("R1 no strobe when idle", issueStrobe, 1'b0);
    end
  endtask

  task automatic t_acqBlocksData;
    issueOne(K_ACQ, "R2 acquire issues");
    probe(K_RD, 1'b0, "R3 read blocked by acquire");
    probe(K_WR, 1'b0, "R3 write blocked by acquire");
    pulse(K_ACQ);
    probe(K_RD, 1'b1, "R10 read ready cycle after acq done");
    issueOne(K_RD, "R3 read issues after acquire done");
  endtask

  // One read outstanding on entry
  task automatic t_releaseOrder;
    probe(K_REL, 1'b0, "R4 release blocked by data");
    issueOne(K_ACQ, "R7 acquire overlaps earlier data");
    probe(K_REL, 1'b0, "R5 release blocked by acquire");
    probe(K_ACQ, 1'b0, "R5 acquire blocked by acquire");
    pulse(K_ACQ);
    probe(K_REL, 1'b0, "R4 release still blocked by data");
    pulse(K_RD);
    issueOne(K_REL, "R4 release issues after data done");
    issueOne(K_WR, "R6 write overlaps outstanding release");
    probe(K_ACQ, 1'b0, "R5 acquire blocked by release");
    probe(K_REL, 1'b0, "R5 release blocked by release");
    pulse(K_REL);
    probe(K_ACQ, 1'b1, "R5 acquire ready after release done");
    pulse(K_WR);
    probe(K_REL, 1'b1, "R4 release ready with no data");
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 15; i++) issueOne(K_WR, "R8 write below limit");
    probe(K_WR, 1'b0, "R8 write blocked at 15");
    probe(K_RD, 1'b0, "R8 read blocked at 15");
    probe(K_ACQ, 1'b1, "R7 acquire ready with 15 data");
    pulse(K_WR);
    probe(K_WR, 1'b1, "R8 write ready at 14");
    // issue and completion together: count stays 14
    @(negedge clk);
    reqValid = 1'b1;
    reqKind  = K_WR;
    doneData = 1'b1;
    #2;
    chk("R10 same-cycle issue accepted", issueStrobe, 1'b1);
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    doneData = 1'b0;
    probe(K_WR, 1'b1, "R10 count held at 14");
    issueOne(K_WR, "R10 fill to 15");
    probe(K_WR, 1'b0, "R10 full again after one issue");
    for (int i = 0; i < 14; i++) pulse(K_WR);
    probe(K_REL, 1'b0, "R4 release blocked with one data left");
    pulse(K_WR);
    probe(K_REL, 1'b1, "R4 release ready after drain");
  endtask

  task automatic t_spurious;
    pulse(K_ACQ);
    pulse(K_REL);
    pulse(K_RD);
    probe(K_RD, 1'b1, "R9 spurious acq done ignored");
    probe(K_REL, 1'b1, "R9 spurious data done ignored");
    probe(K_ACQ, 1'b1, "R9 spurious rel done ignored");
    issueOne(K_ACQ, "R9 acquire after spurious pulses");
    pulse(K_ACQ);
    probe(K_RD, 1'b1, "R9 acquire counter back at zero");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rstN = 1'b1;
        t_reset();
        t_acqBlocksData();
        t_releaseOrder();
        t_saturate();
        t_spurious();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule